// File: doc/BRIEF.md
# Pixel Region Hit Buffer

The block is the digital logic shared by a group of four analog pixels. Each pixel supplies a discriminator level, already synchronous to the bunch-crossing clock. A rising edge on any pixel opens a hit in one of a small pool of shared buffer slots. From then on the block counts how many clock edges the pulse stays high, which gives its time-over-threshold (ToT). It then holds the hit until the trigger latency has elapsed. Pixels that rise on the same edge share one slot, which records them in a hit mask with one ToT field per pixel.

Each slot has its own latency countdown, loaded from the latency input when the slot is opened. When that countdown runs out, the trigger input is sampled once. A slot that sees the trigger becomes ready to read. A slot that does not is returned to the free pool without any indication. Any ready slot raises the token request toward the column readout. The readout sees the lowest-numbered ready slot on the read outputs, and a read strobe releases that slot. If a hit arrives while every slot is occupied, the hit is lost and a sticky overflow flag is raised.

Top module: `pixel_region_buffer`

## Requirements
- R1: A hit is a rising edge: a pixel sampled high at a clock edge after being sampled low at the previous edge. A pixel held high opens no further slot.
- R2: ToT counts the clock edges at which the pixel is sampled high while its slot is waiting. The count starts at 1 on the capture edge and includes the decision edge. Pixel p occupies bits [4p+3:4p] of `rd_tot_o`.
- R3: Pixels that rise on the same edge share one slot. `rd_mask_o` bit p is set when pixel p is part of the hit.
- R4: A new hit takes the lowest-numbered free slot. The read outputs always show the lowest-numbered ready slot, and `rd_slot_o` gives its index.
- R5: A slot opened at edge n with latency L makes its decision at edge n+L+1. If `trig_i` is high at that edge, the slot becomes ready. Otherwise the slot is freed and no token is raised.
- R6: `token_o` is high exactly when at least one slot is ready. When `read_i` is high at an edge while `token_o` is high, the shown slot is freed. When `read_i` is high while `token_o` is low, it has no effect.
- R7: There are five slots. A slot freed at an edge can first be allocated at the following edge.
- R8: When a hit arrives and no slot is free, the hit is discarded and `overflow_o` is set. `overflow_o` then stays high until reset.
- R9: A ToT field saturates at 15.
- R10: After a synchronous active-low reset, all slots are free, `token_o` is low and `overflow_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disc_i | input | 4 | Discriminator level per pixel |
| trig_i | input | 1 | Trigger pulse, sampled at slot decision edges |
| latency_i | input | 8 | Latency preset, loaded when a slot is opened |
| read_i | input | 1 | Read strobe from the column readout |
| token_o | output | 1 | At least one slot is ready to read |
| rd_slot_o | output | 3 | Index of the slot shown on the read outputs |
| rd_mask_o | output | 4 | Hit mask of the shown slot |
| rd_tot_o | output | 16 | Per-pixel ToT of the shown slot, four bits per pixel |
| overflow_o | output | 1 | Sticky flag: a hit was lost because no slot was free |

## Verification
The two functions that can coincide are the release of a slot by a read strobe and the arrival of a new hit on the same edge while every other slot is full. The bench fills all five slots with triggered hits. It then drives a read strobe and a fresh rising edge on one edge. It expects the hit to be lost, with the overflow flag rising, and a hit on a later edge to land in the just-freed lowest slot. A behavioural model of slots and pixel links is compared against the outputs on every cycle. The comparison covers directed sequences and a long run of random hits, triggers, reads and latencies.

// File: rtl/region_pkg.sv
// Shared types for the pixel region hit buffer.
// Assumes: nothing beyond the standard language.
package region_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

endpackage

// File: rtl/region_pick.sv
// Lowest-index priority picker: finds the first set request bit.
// Assumes: N >= 1 and IW wide enough to hold N-1.
module region_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  grant_o
);

    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o    = 1'b1;
                idx_o      = IW'(i);
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/region_pixel_link.sv
// Per-pixel front: detects the rising edge of one discriminator and remembers
// which slot owns the pulse in flight, steering ToT increments to that slot.
// Assumes: disc_i is already synchronous to clk.
module region_pixel_link #(
    parameter int NSLOT = 5,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disc_i,
    input  logic             alloc_ok_i,
    input  logic [IW-1:0]    alloc_idx_i,
    input  logic [NSLOT-1:0] slot_wait_i,
    output logic             rise_o,
    output logic [NSLOT-1:0] inc_o
);

    localparam int PADN = 1 << IW;

    logic          prev_q;
    logic          link_q;
    logic [IW-1:0] owner_q;
    logic [PADN-1:0] wait_pad;

    assign rise_o   = disc_i & ~prev_q;
    assign wait_pad = PADN'(slot_wait_i);

    // Track the previous level and the owning slot of the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            link_q  <= 1'b0;
            owner_q <= '0;
        end else begin
            prev_q <= disc_i;
            if (rise_o && alloc_ok_i) begin
                link_q  <= 1'b1;
                owner_q <= alloc_idx_i;
            end else if (!disc_i || !wait_pad[owner_q]) begin
                link_q <= 1'b0;
            end
        end
    end

    // One increment request per slot, only toward the owner.
    for (genvar k = 0; k < NSLOT; k++) begin : g_inc
        assign inc_o[k] = link_q && disc_i && (owner_q == IW'(k));
    end

endmodule

// File: rtl/region_slot.sv
// One shared buffer slot: hit mask, per-pixel ToT, latency countdown and
// the free / waiting / ready life cycle.
// Assumes: alloc_i only while free, read_i only while ready (enforced above).
module region_slot
    import region_pkg::*;
#(
    parameter int NPIX  = 4,
    parameter int TOT_W = 4,
    parameter int LAT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_i,
    input  logic [NPIX-1:0]       mask_i,
    input  logic [LAT_W-1:0]      lat_i,
    input  logic                  trig_i,
    input  logic [NPIX-1:0]       inc_i,
    input  logic                  read_i,
    output logic                  is_free_o,
    output logic                  is_wait_o,
    output logic                  is_ready_o,
    output logic [NPIX-1:0]       mask_o,
    output logic [NPIX*TOT_W-1:0] tot_o
);

    localparam logic [TOT_W-1:0] TOT_MAX = '1;

    slot_state_e      state_q;
    logic [LAT_W-1:0] cnt_q;
    logic [NPIX-1:0]  mask_q;
    logic [TOT_W-1:0] tot_q [NPIX];

    assign is_free_o  = (state_q == SLOT_FREE);
    assign is_wait_o  = (state_q == SLOT_WAIT);
    assign is_ready_o = (state_q == SLOT_READY);
    assign mask_o     = mask_q;

    for (genvar p = 0; p < NPIX; p++) begin : g_pack
        assign tot_o[p*TOT_W +: TOT_W] = tot_q[p];
    end

    // Slot life cycle, latency countdown and saturating ToT accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            cnt_q   <= '0;
            mask_q  <= '0;
            for (int p = 0; p < NPIX; p++) tot_q[p] <= '0;
        end else begin
            case (state_q)
                SLOT_FREE: begin
                    if (alloc_i) begin
                        state_q <= SLOT_WAIT;
                        cnt_q   <= lat_i;
                        mask_q  <= mask_i;
                        for (int p = 0; p < NPIX; p++)
                            tot_q[p] <= mask_i[p] ? TOT_W'(1) : '0;
                    end
                end
                SLOT_WAIT: begin
                    for (int p = 0; p < NPIX; p++)
                        if (inc_i[p] && tot_q[p] != TOT_MAX)
                            tot_q[p] <= tot_q[p] + TOT_W'(1);
                    if (cnt_q == '0)
                        state_q <= trig_i ? SLOT_READY : SLOT_FREE;
                    else
                        cnt_q <= cnt_q - LAT_W'(1);
                end
                SLOT_READY: begin
                    if (read_i) state_q <= SLOT_FREE;
                end
                default: state_q <= SLOT_FREE;
            endcase
        end
    end

    // R5: an expiring slot with a trigger becomes ready.
    a_r5_keep_triggered: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT && cnt_q == '0 && trig_i) |=> state_q == SLOT_READY);

    // R5: an expiring slot without a trigger is freed.
    a_r5_drop_untriggered: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT && cnt_q == '0 && !trig_i) |=> state_q == SLOT_FREE);

    // R6: a read of a ready slot releases it.
    a_r6_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_READY && read_i) |=> state_q == SLOT_FREE);

    // R9: a saturated ToT field stays at its maximum.
    for (genvar p = 0; p < NPIX; p++) begin : g_sat
        a_r9_tot_saturates: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == SLOT_WAIT && tot_q[p] == TOT_MAX) |=> tot_q[p] == TOT_MAX);
    end

endmodule

// File: rtl/pixel_region_buffer.sv
// Pixel region hit buffer top: per-pixel edge detection and slot links,
// a pool of shared slots, free/ready pickers, read-out mux and overflow flag.
// Assumes: discriminator levels are synchronous to the bunch-crossing clock;
// the readout pulses read_i once per slot it fetches.
module pixel_region_buffer
    import region_pkg::*;
#(
    parameter int NPIX  = 4,
    parameter int NSLOT = 5,
    parameter int TOT_W = 4,
    parameter int LAT_W = 8,
    localparam int SLOT_IW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIX-1:0]       disc_i,
    input  logic                  trig_i,
    input  logic [LAT_W-1:0]      latency_i,
    input  logic                  read_i,
    output logic                  token_o,
    output logic [SLOT_IW-1:0]    rd_slot_o,
    output logic [NPIX-1:0]       rd_mask_o,
    output logic [NPIX*TOT_W-1:0] rd_tot_o,
    output logic                  overflow_o
);

    logic [NPIX-1:0]       rise;
    logic [NSLOT-1:0]      pix_inc [NPIX];
    logic [NSLOT-1:0]      free_vec, wait_vec, ready_vec;
    logic [NSLOT-1:0]      free_grant, ready_grant;
    logic                  free_found, ready_found;
    logic [SLOT_IW-1:0]    free_idx, ready_idx;
    logic                  any_rise;
    logic [NPIX-1:0]       slot_mask [NSLOT];
    logic [NPIX*TOT_W-1:0] slot_tot  [NSLOT];
    logic                  ovf_q;

    assign any_rise = |rise;

    region_pick #(.N(NSLOT), .IW(SLOT_IW)) u_free_pick (
        .req_i   (free_vec),
        .found_o (free_found),
        .idx_o   (free_idx),
        .grant_o (free_grant)
    );

    region_pick #(.N(NSLOT), .IW(SLOT_IW)) u_ready_pick (
        .req_i   (ready_vec),
        .found_o (ready_found),
        .idx_o   (ready_idx),
        .grant_o (ready_grant)
    );

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        region_pixel_link #(.NSLOT(NSLOT), .IW(SLOT_IW)) u_link (
            .clk         (clk),
            .rst_n       (rst_n),
            .disc_i      (disc_i[p]),
            .alloc_ok_i  (free_found),
            .alloc_idx_i (free_idx),
            .slot_wait_i (wait_vec),
            .rise_o      (rise[p]),
            .inc_o       (pix_inc[p])
        );
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic [NPIX-1:0] inc_here;
        for (genvar p = 0; p < NPIX; p++) begin : g_gather
            assign inc_here[p] = pix_inc[p][k];
        end
        region_slot #(.NPIX(NPIX), .TOT_W(TOT_W), .LAT_W(LAT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (free_grant[k] && any_rise),
            .mask_i     (rise),
            .lat_i      (latency_i),
            .trig_i     (trig_i),
            .inc_i      (inc_here),
            .read_i     (ready_grant[k] && read_i),
            .is_free_o  (free_vec[k]),
            .is_wait_o  (wait_vec[k]),
            .is_ready_o (ready_vec[k]),
            .mask_o     (slot_mask[k]),
            .tot_o      (slot_tot[k])
        );
    end

    // Present the lowest ready slot to the column readout.
    always_comb begin
        rd_mask_o = '0;
        rd_tot_o  = '0;
        for (int k = 0; k < NSLOT; k++) begin
            if (ready_grant[k]) begin
                rd_mask_o = rd_mask_o | slot_mask[k];
                rd_tot_o  = rd_tot_o  | slot_tot[k];
            end
        end
    end

    assign token_o    = ready_found;
    assign rd_slot_o  = ready_idx;
    assign overflow_o = ovf_q;

    // Sticky record of a hit lost for lack of a free slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ovf_q <= 1'b0;
        else if (any_rise && !free_found)  ovf_q <= 1'b1;
    end

    // R8: a hit with no free slot raises the flag on the next edge.
    a_r8_lost_hit_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rise && !free_found) |=> overflow_o);

    // R8: the flag holds until reset.
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R7: a hit allocated while a slot was free grows the busy count unless something left.
    a_r7_alloc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rise && free_found && !read_i && wait_vec == '0)
        |=> $countones(free_vec) == $countones($past(free_vec)) - 1);

endmodule

// File: tb/tb_pixel_region_buffer.sv
module tb_pixel_region_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  disc_i = '0;
    logic        trig_i = 1'b0;
    logic [7:0]  latency_i = '0;
    logic        read_i = 1'b0;
    logic        token_o;
    logic [2:0]  rd_slot_o;
    logic [3:0]  rd_mask_o;
    logic [15:0] rd_tot_o;
    logic        overflow_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pixel_region_buffer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .disc_i     (disc_i),
        .trig_i     (trig_i),
        .latency_i  (latency_i),
        .read_i     (read_i),
        .token_o    (token_o),
        .rd_slot_o  (rd_slot_o),
        .rd_mask_o  (rd_mask_o),
        .rd_tot_o   (rd_tot_o),
        .overflow_o (overflow_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural model: 0 free, 1 waiting, 2 ready.
    int st [NS];
    int cnt [NS];
    int msk [NS];
    int tt [NS][NP];
    int lnk [NP];
    int own [NP];
    int prv [NP];
    int ovf;
    int m_rise, m_ff, m_fr;
    int old_st [NS];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) begin
                st[k] = 0; cnt[k] = 0; msk[k] = 0;
                for (int p = 0; p < NP; p++) tt[k][p] = 0;
            end
            for (int p = 0; p < NP; p++) begin lnk[p] = 0; own[p] = 0; prv[p] = 0; end
            ovf = 0;
        end else begin
            m_rise = 0;
            for (int p = 0; p < NP; p++)
                if (disc_i[p] && prv[p] == 0) m_rise = m_rise | (1 << p);
            m_ff = -1; m_fr = -1;
            for (int k = NS - 1; k >= 0; k--) begin
                if (st[k] == 0) m_ff = k;
                if (st[k] == 2) m_fr = k;
                old_st[k] = st[k];
            end
            for (int k = 0; k < NS; k++) begin
                if (old_st[k] == 1) begin
                    for (int p = 0; p < NP; p++)
                        if (lnk[p] == 1 && own[p] == k && disc_i[p] && tt[k][p] < 15)
                            tt[k][p]++;
                    if (cnt[k] == 0) st[k] = trig_i ? 2 : 0;
                    else cnt[k]--;
                end else if (old_st[k] == 2) begin
                    if (read_i && k == m_fr) st[k] = 0;
                end else if (k == m_ff && m_rise != 0) begin
                    st[k] = 1; cnt[k] = int'(latency_i); msk[k] = m_rise;
                    for (int p = 0; p < NP; p++) tt[k][p] = (m_rise >> p) & 1;
                end
            end
            for (int p = 0; p < NP; p++) begin
                if (((m_rise >> p) & 1) == 1 && m_ff >= 0) begin
                    lnk[p] = 1; own[p] = m_ff;
                end else if (!disc_i[p] || old_st[own[p]] != 1) begin
                    lnk[p] = 0;
                end
            end
            if (m_rise != 0 && m_ff < 0) ovf = 1;
            for (int p = 0; p < NP; p++) prv[p] = int'(disc_i[p]);
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic compare();
        int fr;
        int packed_tot;
        fr = -1;
        for (int k = NS - 1; k >= 0; k--) if (st[k] == 2) fr = k;
        chk(int'(token_o), (fr >= 0) ? 1 : 0, "R6 token");
        chk(int'(overflow_o), ovf, "R8 overflow");
        if (fr >= 0) begin
            packed_tot = 0;
            for (int p = 0; p < NP; p++) packed_tot = packed_tot | (tt[fr][p] << (4 * p));
            chk(int'(rd_slot_o), fr, "R4 slot index");
            chk(int'(rd_mask_o), msk[fr], "R3 hit mask");
            chk(int'(rd_tot_o), packed_tot, "R2 tot values");
        end
    endtask

    task automatic cyc(input logic [3:0] d, input logic t, input logic r, input logic [7:0] l);
        disc_i = d; trig_i = t; read_i = r; latency_i = l;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        disc_i = '0; trig_i = 0; read_i = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk(int'(token_o), 0, "R10 token after reset");
        chk(int'(overflow_o), 0, "R10 overflow after reset");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R5: pulse of 3 edges, latency 5, trigger at edge n+6.
        for (int i = 0; i < 3; i++) cyc(4'b0001, 0, 0, 8'd5);
        cyc(4'b0000, 0, 0, 8'd5);
        cyc(4'b0000, 0, 0, 8'd5);
        cyc(4'b0000, 0, 0, 8'd5);
        cyc(4'b0000, 1, 0, 8'd5);
        chk(int'(token_o), 1, "R5 triggered hit ready");
        chk(int'(rd_tot_o[3:0]), 3, "R2 tot of three-edge pulse");
        cyc(4'b0000, 0, 1, 8'd5);
        chk(int'(token_o), 0, "R6 read releases slot");

        // R5: trigger one edge early, hit dropped.
        cyc(4'b0010, 0, 0, 8'd5);
        for (int i = 0; i < 4; i++) cyc(4'b0000, 0, 0, 8'd5);
        cyc(4'b0000, 1, 0, 8'd5);
        cyc(4'b0000, 0, 0, 8'd5);
        chk(int'(token_o), 0, "R5 untriggered hit dropped");

        // R6: read with no token ignored.
        for (int i = 0; i < 3; i++) cyc(4'b0000, 0, 1, 8'd5);
        chk(int'(token_o), 0, "R6 idle read ignored");

        // R1: level held high opens one slot only.
        for (int i = 0; i < 10; i++) cyc(4'b0100, 1, 0, 8'd2);
        cyc(4'b0000, 1, 1, 8'd2);
        chk(int'(token_o), 0, "R1 single slot for held level");

        // R3: pixels 0 and 1 together, pixel 2 one edge later.
        cyc(4'b0011, 1, 0, 8'd3);
        cyc(4'b0111, 1, 0, 8'd3);
        for (int i = 0; i < 4; i++) cyc(4'b0000, 1, 0, 8'd3);
        chk(int'(rd_mask_o), 3, "R3 shared slot mask");
        cyc(4'b0000, 0, 1, 8'd3);
        chk(int'(rd_mask_o), 4, "R3 separate slot for later edge");
        chk(int'(rd_slot_o), 1, "R4 second slot index");
        cyc(4'b0000, 0, 1, 8'd3);

        // R9: long pulse saturates.
        for (int i = 0; i < 20; i++) cyc(4'b1000, 1, 0, 8'd30);
        for (int i = 0; i < 15; i++) cyc(4'b0000, 1, 0, 8'd30);
        chk(int'(rd_tot_o[15:12]), 15, "R9 tot saturates");
        cyc(4'b0000, 0, 1, 8'd30);

        // R8: sixth hit while five slots wait.
        for (int i = 0; i < 5; i++) begin
            cyc(4'b0001, 0, 0, 8'd60);
            cyc(4'b0000, 0, 0, 8'd60);
        end
        chk(int'(overflow_o), 0, "R8 five hits fit");
        cyc(4'b0001, 0, 0, 8'd60);
        cyc(4'b0000, 0, 0, 8'd60);
        chk(int'(overflow_o), 1, "R8 sixth hit overflows");
        for (int i = 0; i < 70; i++) cyc(4'b0000, 0, 0, 8'd60);
        chk(int'(overflow_o), 1, "R8 flag sticky");

        // R7: read and hit on the same edge with all slots ready.
        do_reset();
        for (int i = 0; i < 5; i++) begin
            cyc(4'b0010, 1, 0, 8'd10);
            cyc(4'b0000, 1, 0, 8'd10);
        end
        for (int i = 0; i < 15; i++) cyc(4'b0000, 1, 0, 8'd10);
        cyc(4'b0010, 0, 1, 8'd10);
        chk(int'(overflow_o), 1, "R7 freed slot not reused same edge");
        cyc(4'b0000, 0, 0, 8'd10);
        cyc(4'b0010, 0, 0, 8'd10);
        chk(int'(rd_slot_o), 1, "R7 remaining ready slots");

        // Random traffic.
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] d;
            d = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            cyc(d, ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 1),
                8'($urandom_range(0, 12)));
        end

        finish_run();
    end

endmodule